// File: doc/BRIEF.md
# ECC Error Status and Capture

This block gathers error reports from the checking logic of two protected memories. One is a RAM built from a large and a small array. The other is a flash. Each memory can report a single-bit correction or an uncorrectable error. For every report type there is a sticky flag, and there is one combined interrupt request. When an enabled report is accepted, the block also stores the failing address, the access attributes and the data word. The RAM and the flash each have their own capture set.

Only one report is accepted per cycle. When several arrive together, a fixed priority picks the winner: RAM correction first, then flash correction, then RAM uncorrectable, then flash uncorrectable. If both RAM arrays report the winning kind in the same cycle, the large array is chosen. Software reads the flags and the capture words through a small word-addressed register port. It clears flags by writing ones to them.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, every flag, every capture word and the interrupt output read as zero.
- R2: An enabled RAM uncorrectable report with no higher-priority report in the same cycle sets flag bit 2. The flag can be read on the next cycle, and the interrupt is then high while enable bit 2 is high.
- R3: An enabled flash uncorrectable report with no higher-priority report sets flag bit 3 on the next cycle, and the interrupt goes high.
- R4: A write to register 0 clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R5: If hardware sets a flag in the same cycle that software clears it, the flag stays set.
- R6: Among the enabled reports of one cycle, only the winner sets its flag. The winner is chosen by flag-bit priority: bit 0 RAM correction, bit 1 flash correction, bit 2 RAM uncorrectable, bit 3 flash uncorrectable, with bit 0 the highest.
- R7: If both RAM arrays report the winning RAM kind in the same cycle, the large array's address, attributes and data are captured. Bit ATTR_W of register 2 then reads 0. When the small array is captured, that bit reads 1.
- R8: When a RAM report wins, the RAM capture registers are loaded on the next cycle: register 1 with the address, register 2 bits ATTR_W-1:0 with the attributes, and register 3 with the data. At all other times they hold their value.
- R9: When a flash report wins, registers 4, 5 and 6 are loaded with the flash address, attributes and data. At all other times they hold their value.
- R10: The interrupt output is high exactly when some flag bit is set and its enable input bit is high.
- R11: A report whose enable bit is low sets no flag and loads no capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ram_big_ce | input | 1 | Large RAM array single-bit correction report |
| ram_big_nce | input | 1 | Large RAM array uncorrectable report |
| ram_big_addr | input | ADDR_W | Large array failing address |
| ram_big_attr | input | ATTR_W | Large array access attributes |
| ram_big_data | input | DATA_W | Large array data word |
| ram_small_ce | input | 1 | Small RAM array single-bit correction report |
| ram_small_nce | input | 1 | Small RAM array uncorrectable report |
| ram_small_addr | input | ADDR_W | Small array failing address |
| ram_small_attr | input | ATTR_W | Small array access attributes |
| ram_small_data | input | DATA_W | Small array data word |
| fl_ce | input | 1 | Flash single-bit correction report |
| fl_nce | input | 1 | Flash uncorrectable report |
| fl_addr | input | ADDR_W | Flash failing address |
| fl_attr | input | ATTR_W | Flash access attributes |
| fl_data | input | DATA_W | Flash data word |
| kind_en | input | 4 | Per-kind report enables, bit order as in R6 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index (0 flags, 1 to 3 RAM capture, 4 to 6 flash capture) |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, combinational from reg_addr |
| irq | output | 1 | Combined ECC interrupt request |

## Verification
The assertions assume that the checking logic of each memory drives its report lines and payload in the same cycle, and that the report inputs are low during reset. The bench meets both assumptions. It holds every report and write strobe low through reset. It changes stimulus only on the falling edge, presenting a whole cycle's reports together with their address, attributes and data. Random cycles turn on each report line with a probability of one in four. This makes same-cycle collisions and set-versus-clear overlaps common. Directed cycles add the array tie and the disabled-report cases.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
    // report kinds; the numeric value is both flag bit and priority rank
    typedef enum logic [1:0] {
        KIND_RAM_CORR = 2'd0,
        KIND_FL_CORR  = 2'd1,
        KIND_RAM_UNC  = 2'd2,
        KIND_FL_UNC   = 2'd3
    } err_kind_e;

    localparam int NUM_KINDS = 4;
    localparam int REG_IDX_W = 3;

    localparam logic [REG_IDX_W-1:0] IDX_FLAGS    = 3'd0;
    localparam logic [REG_IDX_W-1:0] IDX_RAM_ADDR = 3'd1;
    localparam logic [REG_IDX_W-1:0] IDX_RAM_ATTR = 3'd2;
    localparam logic [REG_IDX_W-1:0] IDX_RAM_DATA = 3'd3;
    localparam logic [REG_IDX_W-1:0] IDX_FL_ADDR  = 3'd4;
    localparam logic [REG_IDX_W-1:0] IDX_FL_ATTR  = 3'd5;
    localparam logic [REG_IDX_W-1:0] IDX_FL_DATA  = 3'd6;
endpackage

// File: rtl/ecc_kind_arbiter.sv
module ecc_kind_arbiter #(
    parameter int NK = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NK-1:0] req_i,
    input  logic [NK-1:0] en_i,
    output logic [NK-1:0] win_o
);
    logic [NK-1:0] live;
    logic [NK:0]   taken;

    assign live     = req_i & en_i;
    assign taken[0] = 1'b0;

    // lowest index wins; taken[k] says a higher-priority kind is live
    for (genvar k = 0; k < NK; k++) begin : g_rank
        assign win_o[k]   = live[k] & ~taken[k];
        assign taken[k+1] = taken[k] | live[k];
    end

    // at most one winner, and never a disabled kind
    assert_one_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_o));
    assert_disabled_loses_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (win_o & ~en_i) == '0);
endmodule

// File: rtl/ecc_flag_bank.sv
module ecc_flag_bank #(
    parameter int NK = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NK-1:0] set_i,
    input  logic [NK-1:0] clr_i,
    input  logic [NK-1:0] en_i,
    output logic [NK-1:0] flag_o,
    output logic          irq_o
);
    logic [NK-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_i) | set_i;   // set beats clear
    end

    assign flag_o = flag_q;
    assign irq_o  = |(flag_q & en_i);

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));
    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((flag_q & $past(clr_i & ~set_i)) == '0));
    assert_no_spurious_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_i)) == '0));
    assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_q != '0));
endmodule

// File: rtl/ecc_capture_set.sv
module ecc_capture_set #(
    parameter int AW = 32,
    parameter int TW = 9,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] addr_i,
    input  logic [TW-1:0] attr_i,
    input  logic [DW-1:0] data_i,
    output logic [AW-1:0] addr_o,
    output logic [TW-1:0] attr_o,
    output logic [DW-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
            attr_o <= '0;
            data_o <= '0;
        end else if (load_i) begin
            addr_o <= addr_i;
            attr_o <= attr_i;
            data_o <= data_i;
        end
    end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ATTR_W = 8,
    parameter int REG_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ram_big_ce,
    input  logic                 ram_big_nce,
    input  logic [ADDR_W-1:0]    ram_big_addr,
    input  logic [ATTR_W-1:0]    ram_big_attr,
    input  logic [DATA_W-1:0]    ram_big_data,
    input  logic                 ram_small_ce,
    input  logic                 ram_small_nce,
    input  logic [ADDR_W-1:0]    ram_small_addr,
    input  logic [ATTR_W-1:0]    ram_small_attr,
    input  logic [DATA_W-1:0]    ram_small_data,
    input  logic                 fl_ce,
    input  logic                 fl_nce,
    input  logic [ADDR_W-1:0]    fl_addr,
    input  logic [ATTR_W-1:0]    fl_attr,
    input  logic [DATA_W-1:0]    fl_data,
    input  logic [3:0]           kind_en,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 irq
);
    localparam int RTW = ATTR_W + 1;   // RAM attributes plus array-select bit

    logic [NUM_KINDS-1:0] kind_req, kind_win, flag_clr, flags;
    logic                 ram_win, fl_win, pick_small;
    logic [ADDR_W-1:0]    ram_addr_sel, ram_addr_q, fl_addr_q;
    logic [RTW-1:0]       ram_attr_sel, ram_attr_q;
    logic [ATTR_W-1:0]    fl_attr_q;
    logic [DATA_W-1:0]    ram_data_sel, ram_data_q, fl_data_q;

    always_comb begin
        kind_req[KIND_RAM_CORR] = ram_big_ce  | ram_small_ce;
        kind_req[KIND_FL_CORR]  = fl_ce;
        kind_req[KIND_RAM_UNC]  = ram_big_nce | ram_small_nce;
        kind_req[KIND_FL_UNC]   = fl_nce;
    end

    ecc_kind_arbiter #(.NK(NUM_KINDS)) u_arb (
        .clk(clk), .rst_n(rst_n), .req_i(kind_req), .en_i(kind_en), .win_o(kind_win)
    );

    assign ram_win = kind_win[KIND_RAM_CORR] | kind_win[KIND_RAM_UNC];
    assign fl_win  = kind_win[KIND_FL_CORR]  | kind_win[KIND_FL_UNC];

    // large array preferred when it carries the winning RAM kind
    always_comb begin
        pick_small = kind_win[KIND_RAM_CORR] ? ~ram_big_ce : ~ram_big_nce;
        if (pick_small) begin
            ram_addr_sel = ram_small_addr;
            ram_attr_sel = {1'b1, ram_small_attr};
            ram_data_sel = ram_small_data;
        end else begin
            ram_addr_sel = ram_big_addr;
            ram_attr_sel = {1'b0, ram_big_attr};
            ram_data_sel = ram_big_data;
        end
    end

    assign flag_clr = (reg_wr && reg_addr == IDX_FLAGS) ? reg_wdata[NUM_KINDS-1:0] : '0;

    ecc_flag_bank #(.NK(NUM_KINDS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(kind_win), .clr_i(flag_clr),
        .en_i(kind_en), .flag_o(flags), .irq_o(irq)
    );

    ecc_capture_set #(.AW(ADDR_W), .TW(RTW), .DW(DATA_W)) u_ram_cap (
        .clk(clk), .rst_n(rst_n), .load_i(ram_win),
        .addr_i(ram_addr_sel), .attr_i(ram_attr_sel), .data_i(ram_data_sel),
        .addr_o(ram_addr_q), .attr_o(ram_attr_q), .data_o(ram_data_q)
    );

    ecc_capture_set #(.AW(ADDR_W), .TW(ATTR_W), .DW(DATA_W)) u_fl_cap (
        .clk(clk), .rst_n(rst_n), .load_i(fl_win),
        .addr_i(fl_addr), .attr_i(fl_attr), .data_i(fl_data),
        .addr_o(fl_addr_q), .attr_o(fl_attr_q), .data_o(fl_data_q)
    );

    always_comb begin
        unique case (reg_addr)
            IDX_FLAGS:    reg_rdata = REG_W'(flags);
            IDX_RAM_ADDR: reg_rdata = REG_W'(ram_addr_q);
            IDX_RAM_ATTR: reg_rdata = REG_W'(ram_attr_q);
            IDX_RAM_DATA: reg_rdata = REG_W'(ram_data_q);
            IDX_FL_ADDR:  reg_rdata = REG_W'(fl_addr_q);
            IDX_FL_ATTR:  reg_rdata = REG_W'(fl_attr_q);
            IDX_FL_DATA:  reg_rdata = REG_W'(fl_data_q);
            default:      reg_rdata = '0;
        endcase
    end

    assert_big_array_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_win[KIND_RAM_UNC] && ram_big_nce) |=> (ram_attr_q[ATTR_W] == 1'b0));
    assert_ram_capture_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_win |=> ($stable(ram_addr_q) && $stable(ram_data_q)));
    assert_flash_capture_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_win |=> ($stable(fl_addr_q) && $stable(fl_data_q)));
endmodule

// File: tb/ecc_err_capture_bench.sv
`timescale 1ns/1ps
module ecc_err_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ram_big_ce = 0, ram_big_nce = 0, ram_small_ce = 0, ram_small_nce = 0;
    logic        fl_ce = 0, fl_nce = 0;
    logic [31:0] ram_big_addr = 0, ram_big_data = 0, ram_small_addr = 0, ram_small_data = 0;
    logic [31:0] fl_addr = 0, fl_data = 0;
    logic [7:0]  ram_big_attr = 0, ram_small_attr = 0, fl_attr = 0;
    logic [3:0]  kind_en = 4'hF;
    logic        reg_wr = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model
    logic [3:0]  m_flags = 0;
    logic [31:0] m_raddr = 0, m_rdata = 0, m_faddr = 0, m_fdata = 0;
    logic [8:0]  m_rattr = 0;
    logic [7:0]  m_fattr = 0;

    always #2.5 clk = ~clk;

    ecc_err_capture u_ecc_err_capture (.*);

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_reg(int idx);
        case (idx)
            0: return {28'd0, m_flags};
            1: return m_raddr;
            2: return {23'd0, m_rattr};
            3: return m_rdata;
            4: return m_faddr;
            5: return {24'd0, m_fattr};
            6: return m_fdata;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string def_tag(int idx);
        if (idx == 0) return "R6";
        if (idx < 4)  return "R8";
        return "R9";
    endfunction

    // compare every readable word and the interrupt with the model
    task automatic check_all(string tag);
        for (int a = 0; a < 7; a++) begin
            reg_addr = a[2:0];
            #0.2;
            chk(tag == "" ? def_tag(a) : tag, $sformatf("reg%0d", a), reg_rdata, model_reg(a));
        end
        chk(tag == "" ? "R10" : tag, "irq", {31'd0, irq}, {31'd0, |(m_flags & kind_en)});
    endtask

    task automatic clear_stim();
        {ram_big_ce, ram_big_nce, ram_small_ce, ram_small_nce, fl_ce, fl_nce} = '0;
        reg_wr = 0;
        reg_wdata = 0;
    endtask

    // one clocked cycle with the currently driven stimulus, then check
    task automatic cycle(string tag);
        logic [3:0] act, win, clr;
        act[0] = (ram_big_ce | ram_small_ce) & kind_en[0];
        act[1] = fl_ce & kind_en[1];
        act[2] = (ram_big_nce | ram_small_nce) & kind_en[2];
        act[3] = fl_nce & kind_en[3];
        win = 4'b0000;
        if (act[0]) win = 4'b0001;
        else if (act[1]) win = 4'b0010;
        else if (act[2]) win = 4'b0100;
        else if (act[3]) win = 4'b1000;
        clr = (reg_wr && reg_addr == 3'd0) ? reg_wdata[3:0] : 4'b0000;
        @(posedge clk);
        m_flags = (m_flags & ~clr) | win;
        if (win[0] || win[2]) begin
            if ((win[0] && ram_big_ce) || (win[2] && ram_big_nce)) begin
                m_raddr = ram_big_addr; m_rattr = {1'b0, ram_big_attr}; m_rdata = ram_big_data;
            end else begin
                m_raddr = ram_small_addr; m_rattr = {1'b1, ram_small_attr}; m_rdata = ram_small_data;
            end
        end
        if (win[1] || win[3]) begin
            m_faddr = fl_addr; m_fattr = fl_attr; m_fdata = fl_data;
        end
        @(negedge clk);
        clear_stim();
        check_all(tag);
    endtask

    task automatic rand_payload();
        ram_big_addr = $urandom; ram_big_attr = 8'($urandom); ram_big_data = $urandom;
        ram_small_addr = $urandom; ram_small_attr = 8'($urandom); ram_small_data = $urandom;
        fl_addr = $urandom; fl_attr = 8'($urandom); fl_data = $urandom;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");                                     // R1 reset state

        rand_payload(); ram_big_nce = 1; cycle("R2");        // R2 RAM uncorrectable
        rand_payload(); fl_nce = 1; cycle("R3");             // R3 flash uncorrectable
        reg_wr = 1; reg_addr = 0; reg_wdata = 32'h0; cycle("R4");   // R4 zero write keeps
        reg_wr = 1; reg_addr = 0; reg_wdata = 32'h4; cycle("R4");   // R4 clear bit 2
        rand_payload(); fl_nce = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 32'h8;
        cycle("R5");                                         // R5 set beats clear
        reg_wr = 1; reg_addr = 0; reg_wdata = 32'hF; cycle("R4");
        rand_payload();
        {ram_big_ce, ram_small_nce, fl_ce, fl_nce} = 4'hF; cycle("R6");  // R6 all kinds
        reg_wr = 1; reg_addr = 0; reg_wdata = 32'hF; cycle("R4");
        rand_payload(); fl_ce = 1; fl_nce = 1; ram_big_nce = 1; cycle("R6");
        rand_payload(); ram_big_nce = 1; ram_small_nce = 1; cycle("R7");  // R7 tie
        rand_payload(); ram_small_ce = 1; ram_big_nce = 1; cycle("R7");   // small correction wins
        rand_payload(); ram_small_nce = 1; cycle("R8");      // R8 small array capture
        reg_wr = 1; reg_addr = 0; reg_wdata = 32'hF; cycle("R4");
        kind_en = 4'b1011; rand_payload(); ram_big_nce = 1; cycle("R11"); // R11 disabled
        kind_en = 4'b0000; rand_payload(); fl_ce = 1; ram_small_ce = 1; cycle("R11");
        kind_en = 4'b1111; rand_payload(); fl_ce = 1; cycle("R10");
        kind_en = 4'b1101; check_all("R10");                 // R10 enable masks irq
        kind_en = 4'b1111;

        for (int i = 0; i < 1500; i++) begin
            rand_payload();
            ram_big_ce    = ($urandom_range(0, 3) == 0);
            ram_big_nce   = ($urandom_range(0, 3) == 0);
            ram_small_ce  = ($urandom_range(0, 3) == 0);
            ram_small_nce = ($urandom_range(0, 3) == 0);
            fl_ce         = ($urandom_range(0, 3) == 0);
            fl_nce        = ($urandom_range(0, 3) == 0);
            for (int k = 0; k < 4; k++) kind_en[k] = ($urandom_range(0, 7) != 0);
            reg_wr    = ($urandom_range(0, 5) == 0);
            reg_addr  = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
            reg_wdata = $urandom;
            cycle("");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule